// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a 16K x 8 byte-addressed memory. A host drives it as an SPI slave through chip select, serial clock, serial data in and a hold input. The block returns read data on a serial output that has its own tri-state enable. Each transaction starts with an 8-bit command. Read and write commands are followed by a 16-bit address. Data bytes then stream in or out while chip select stays low, and an internal address counter advances by one location after every byte. The block reaches the storage array through a simple synchronous byte port. It leaves all write-permission policy to a separate protection unit. It asks that unit for a grant on every write and sends it a pulse for each command event. It also reads the status byte it reports from that unit.

All four serial inputs pass through two-stage synchronizers into the system clock, and clock edges are detected there. The system clock must run at least four times faster than the serial clock. Both clock polarities are accepted: idle-low with sampling on the first edge (mode 0), and idle-high with sampling on the second edge (mode 3). The hold input pauses a transaction without ending it. Raising chip select always returns the controller to waiting for a new command.

Top module: `spi_mem_slave`

## Requirements
- R1: Serial data in is captured on rising serial-clock edges and serial data out changes on falling edges, most significant bit first. This holds whether the clock idles low (mode 0) or high (mode 3) while chip select is high.
- R2: Commands decode as 8'h06 set-enable, 8'h04 clear-enable, 8'h05 status read, 8'h01 status write, 8'h03 memory read and 8'h02 memory write. Any other code causes no event, no array access and no output drive for the rest of that transaction.
- R3: When chip select rises before the eighth command bit, no command takes effect.
- R4: Read and write commands take a 16-bit address, most significant bit first. Only its low 14 bits select the location.
- R5: Each complete data byte of a write goes to the array in one write strobe at the current address. Later bytes in the same transaction go to successive addresses.
- R6: A read outputs the byte at the start address and then successive bytes for as long as the serial clock keeps running with chip select low.
- R7: The address counter steps from 14'h3FFF to 14'h0000 on both reads and writes.
- R8: During a status read, the status byte is sent again every 8 clocks until chip select rises, and serial data in is ignored.
- R9: The output enable is low after reset, whenever chip select is high, and in every phase that is not a read-data phase.
- R10: While chip select is low, holding the hold input low freezes the transaction. Serial clock and data are ignored and the output enable drops. Hold entry and exit take effect only while the serial clock is low.
- R11: When chip select rises during hold, the command is aborted: its pending data byte is never written, and the next transaction decodes a new command.
- R12: A write strobe reaches the array only when the protection grant is high for the target address. A refused byte is dropped, but the address still advances.
- R13: Set-enable and clear-enable each give a one-cycle event pulse when the command completes. A status write gives a pulse together with its data byte after 8 data bits. The end of any transaction that carried a memory-write command gives a write-end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data from host |
| spi_hold_n | input | 1 | Hold request, active low |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Output enable for spi_so |
| mem_addr | output | AW | Array byte address |
| mem_re | output | 1 | Array read request; data is held from the next cycle until the next request |
| mem_rdata | input | 8 | Array read data |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| wr_grant | input | 1 | Protection grant for the write at mem_addr |
| stat_byte | input | 8 | Status byte supplied by the protection unit |
| ev_wren | output | 1 | Set-enable command event |
| ev_wrdi | output | 1 | Clear-enable command event |
| ev_wrsr | output | 1 | Status write event |
| ev_data | output | 8 | Data byte of the last status write |
| ev_wr_end | output | 1 | A memory-write transaction ended |

## Verification
The bench targets the address wrap at 14'h3FFF in both directions. A design that carried into the ignored upper bits would write or read the wrong location. Refused writes are placed so that the next granted byte shows whether the address stepped past the refused one. A design that held the address would put that byte one location too low.

Hold is tested with a release while the clock is high. A design that ended hold early would take a spurious edge and shift the read data by one bit. Hold is also ended by a chip-select rise in the middle of a byte, which must neither write a partial byte nor corrupt the next command. Truncated commands and unknown codes must produce no events and no output drive.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_si,
  input  logic          spi_hold_n,
  output logic          spi_so,
  output logic          spi_so_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic          wr_grant,
  input  logic [7:0]    stat_byte,
  output logic          ev_wren,
  output logic          ev_wrdi,
  output logic          ev_wrsr,
  output logic [7:0]    ev_data,
  output logic          ev_wr_end
);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);
  localparam logic [3:0]    LAST_BIT = 4'd7;
  localparam logic [3:0]    LAST_ADR = 4'd15;

  typedef enum logic [2:0] {S_OP, S_ADR, S_WDAT, S_RDAT, S_SRIN, S_SROUT, S_IDLE} st_t;

  logic [1:0] cs_p, sck_p, si_p, hold_p;
  logic       cs_s, sck_s, si_s, hold_s, sck_d, cs_d;
  logic       hold_act, rise, fall;
  st_t        st;
  logic [3:0] cnt;
  logic [6:0] sh;
  logic [7:0] sh_n, so_sh, wd_q;
  logic [AW-1:0] adr;
  logic       is_wr, so_en, re_q, wr_pend;

  assign cs_s   = cs_p[1];
  assign sck_s  = sck_p[1];
  assign si_s   = si_p[1];
  assign hold_s = hold_p[1];
  assign rise   = sck_s & ~sck_d & ~cs_s & ~hold_act;
  assign fall   = ~sck_s & sck_d & ~cs_s & ~hold_act;
  assign sh_n   = {sh, si_s};

  assign spi_so    = so_sh[7];
  assign spi_so_oe = so_en & ~hold_act & ~cs_s;
  assign mem_addr  = adr;
  assign mem_re    = re_q;
  assign mem_we    = wr_pend & wr_grant;
  assign mem_wdata = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= 2'b11;
      sck_p  <= 2'b00;
      si_p   <= 2'b00;
      hold_p <= 2'b11;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      cs_p   <= {cs_p[0], spi_cs_n};
      sck_p  <= {sck_p[0], spi_sck};
      si_p   <= {si_p[0], spi_si};
      hold_p <= {hold_p[0], spi_hold_n};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OP;
      cnt       <= '0;
      sh        <= '0;
      so_sh     <= '0;
      wd_q      <= '0;
      adr       <= '0;
      is_wr     <= 1'b0;
      so_en     <= 1'b0;
      re_q      <= 1'b0;
      wr_pend   <= 1'b0;
      hold_act  <= 1'b0;
      ev_wren   <= 1'b0;
      ev_wrdi   <= 1'b0;
      ev_wrsr   <= 1'b0;
      ev_data   <= '0;
      ev_wr_end <= 1'b0;
    end else begin
      ev_wren   <= 1'b0;
      ev_wrdi   <= 1'b0;
      ev_wrsr   <= 1'b0;
      ev_wr_end <= 1'b0;
      re_q      <= 1'b0;
      wr_pend   <= 1'b0;
      if (wr_pend) adr <= adr + ADR_ONE;
      if (cs_s) begin
        st        <= S_OP;
        cnt       <= '0;
        so_en     <= 1'b0;
        is_wr     <= 1'b0;
        hold_act  <= 1'b0;
        ev_wr_end <= ~cs_d & is_wr;
      end else begin
        if (!sck_s) hold_act <= ~hold_s;
        if (rise) begin
          cnt <= cnt + 4'd1;
          sh  <= sh_n[6:0];
          case (st)
            S_OP: if (cnt == LAST_BIT) begin
              cnt <= '0;
              case (sh_n)
                8'h06:   begin ev_wren <= 1'b1; st <= S_IDLE; end
                8'h04:   begin ev_wrdi <= 1'b1; st <= S_IDLE; end
                8'h05:   st <= S_SROUT;
                8'h01:   st <= S_SRIN;
                8'h03:   begin st <= S_ADR; is_wr <= 1'b0; end
                8'h02:   begin st <= S_ADR; is_wr <= 1'b1; end
                default: st <= S_IDLE;
              endcase
            end
            S_ADR: begin
              adr <= {adr[AW-2:0], si_s};
              if (cnt == LAST_ADR) begin
                cnt  <= '0;
                st   <= is_wr ? S_WDAT : S_RDAT;
                re_q <= ~is_wr;
              end
            end
            S_WDAT: if (cnt == LAST_BIT) begin
              cnt     <= '0;
              wd_q    <= sh_n;
              wr_pend <= 1'b1;
            end
            S_SRIN: if (cnt == LAST_BIT) begin
              ev_wrsr <= 1'b1;
              ev_data <= sh_n;
              st      <= S_IDLE;
            end
            S_RDAT, S_SROUT: if (cnt == LAST_BIT) cnt <= '0;
            default: ;
          endcase
        end
        if (fall) begin
          case (st)
            S_RDAT: if (cnt == '0) begin
              so_sh <= mem_rdata;
              so_en <= 1'b1;
              adr   <= adr + ADR_ONE;
              re_q  <= 1'b1;
            end else so_sh <= {so_sh[6:0], 1'b0};
            S_SROUT: if (cnt == '0) begin
              so_sh <= stat_byte;
              so_en <= 1'b1;
            end else so_sh <= {so_sh[6:0], 1'b0};
            default: ;
          endcase
        end
      end
    end
  end

  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_addr_steps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_addr == $past(mem_addr) + ADR_ONE);

  assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_so_oe);

  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && $past(hold_act)) |-> ($stable(cnt) && $stable(st)));

  assert_one_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_wren, ev_wrdi, ev_wrsr, ev_wr_end}));
endmodule

// File: tb/sim_spi_mem_slave.sv
`timescale 1ns/1ps
module sim_spi_mem_slave;
  localparam int HALF = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic spi_so, spi_so_oe, mem_re, mem_we, wr_grant;
  logic [13:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00, mem_wdata, ev_data;
  logic [7:0] stat_byte = 8'hA6;
  logic ev_wren, ev_wrdi, ev_wrsr, ev_wr_end;
  logic deny_en = 1'b0;
  bit mode3 = 1'b0;
  bit done = 1'b0;

  int nchk = 0, nfail = 0;
  int wcnt = 0, n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_wrend = 0;
  logic [7:0] last_sr = 8'h00;
  logic [13:0] wl_a [256];
  logic [7:0]  wl_d [256];

  spi_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .wr_grant(wr_grant),
    .stat_byte(stat_byte), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
    .ev_wrsr(ev_wrsr), .ev_data(ev_data), .ev_wr_end(ev_wr_end)
  );

  function automatic logic [7:0] pat(input logic [13:0] a);
    return 8'(a * 37) ^ 8'(a >> 6);
  endfunction

  assign wr_grant = !(deny_en && mem_addr[13:12] == 2'b11);

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= pat(mem_addr);
    if (mem_we) begin
      wl_a[wcnt % 256] <= mem_addr;
      wl_d[wcnt % 256] <= mem_wdata;
      wcnt <= wcnt + 1;
    end
    if (ev_wren) n_wren <= n_wren + 1;
    if (ev_wrdi) n_wrdi <= n_wrdi + 1;
    if (ev_wrsr) begin n_wrsr <= n_wrsr + 1; last_sr <= ev_data; end
    if (ev_wr_end) n_wrend <= n_wrend + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic o, output logic e);
    sck = 1'b0; si = b; #(HALF);
    o = spi_so; e = spi_so_oe;
    sck = 1'b1; #(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output int oen);
    logic o, e;
    oen = 0;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], o, e);
      rx[i] = o;
      if (e) oen++;
    end
  endtask

  task automatic begin_tx();
    sck = mode3; #(HALF);
    cs_n = 1'b0; #(HALF);
  endtask

  task automatic end_tx();
    if (!mode3) sck = 1'b0;
    #(HALF);
    cs_n = 1'b1; #(HALF * 4);
  endtask

  task automatic cmd_only(input logic [7:0] op);
    logic [7:0] rx; int oen;
    begin_tx(); xbyte(op, rx, oen); end_tx();
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string req);
    logic [7:0] rx; int oen, hdr;
    logic [13:0] ea;
    hdr = 0;
    begin_tx();
    xbyte(8'h03, rx, oen); hdr += oen;
    xbyte(a[15:8], rx, oen); hdr += oen;
    xbyte(a[7:0], rx, oen); hdr += oen;
    chk(hdr == 0, "R9", "drive during header", hdr, 0);
    for (int i = 0; i < n; i++) begin
      ea = a[13:0] + 14'(i);
      xbyte(8'($urandom), rx, oen);
      chk(rx == pat(ea), req, "read byte", rx, pat(ea));
      chk(oen == 8, "R9", "read drive", oen, 8);
    end
    end_tx();
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input string req);
    logic [7:0] rx; int oen, base, k, e0;
    logic [7:0] d [8];
    logic [13:0] ea;
    base = wcnt; e0 = n_wrend;
    begin_tx();
    xbyte(8'h02, rx, oen);
    xbyte(a[15:8], rx, oen);
    xbyte(a[7:0], rx, oen);
    for (int i = 0; i < n; i++) begin
      d[i] = 8'($urandom);
      xbyte(d[i], rx, oen);
      chk(oen == 0, "R9", "drive during write", oen, 0);
    end
    end_tx();
    k = base;
    for (int i = 0; i < n; i++) begin
      ea = a[13:0] + 14'(i);
      if (!(deny_en && ea[13:12] == 2'b11)) begin
        chk(k < wcnt && wl_a[k % 256] == ea, req, "write addr", int'(wl_a[k % 256]), int'(ea));
        chk(k < wcnt && wl_d[k % 256] == d[i], req, "write data", int'(wl_d[k % 256]), int'(d[i]));
        k++;
      end
    end
    chk(wcnt == k, "R12", "strobe count", wcnt - base, k - base);
    chk(n_wrend == e0 + 1, "R13", "write-end event", n_wrend, e0 + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx; int oen, w0, e0, e1, e2;
    logic o;
    void'($urandom(32'h5EED));
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!spi_so_oe && !mem_we && !mem_re, "R9", "reset outputs", {spi_so_oe, mem_we, mem_re}, 0);

    mode3 = 1'b0; e0 = n_wren; cmd_only(8'h06);
    chk(n_wren == e0 + 1, "R13", "set-enable event mode0", n_wren, e0 + 1);
    mode3 = 1'b1; e0 = n_wrdi; cmd_only(8'h04);
    chk(n_wrdi == e0 + 1, "R2", "clear-enable event mode3", n_wrdi, e0 + 1);

    e0 = n_wren;
    begin_tx();
    for (int i = 0; i < 5; i++) xbit(1'b0, o, o);
    end_tx();
    begin_tx();
    xbit(1'b1, o, o); xbit(1'b1, o, o); xbit(1'b0, o, o);
    end_tx();
    chk(n_wren == e0, "R3", "truncated command", n_wren, e0);

    mode3 = 1'b0;
    e0 = n_wren + n_wrdi + n_wrsr + n_wrend; w0 = wcnt;
    begin_tx(); xbyte(8'hAA, rx, oen); xbyte(8'h55, rx, oen); xbyte(8'h03, rx, oen); end_tx();
    chk(n_wren + n_wrdi + n_wrsr + n_wrend == e0 && wcnt == w0, "R2", "unknown code events", n_wren + n_wrdi + n_wrsr + n_wrend, e0);
    chk(oen == 0, "R9", "unknown code drive", oen, 0);

    e0 = n_wrsr;
    begin_tx(); xbyte(8'h01, rx, oen); xbyte(8'h8C, rx, oen);
    chk(oen == 0, "R9", "status write drive", oen, 0);
    end_tx();
    chk(n_wrsr == e0 + 1 && last_sr == 8'h8C, "R13", "status write data", last_sr, 8'h8C);

    for (int m = 0; m < 2; m++) begin
      mode3 = m[0];
      stat_byte = m[0] ? 8'h3C : 8'hA6;
      begin_tx(); xbyte(8'h05, rx, oen);
      for (int j = 0; j < 3; j++) begin
        xbyte(8'($urandom), rx, oen);
        chk(rx == stat_byte && oen == 8, "R8", "status repeat (R1 mode)", rx, stat_byte);
      end
      end_tx();
    end

    mode3 = 1'b0; do_write(16'hC123, 3, "R4");
    mode3 = 1'b1; do_write(16'h3FFE, 3, "R7");
    mode3 = 1'b0; do_read(16'hFFFF, 3, "R7");
    mode3 = 1'b1; do_read(16'h0040, 4, "R6");

    deny_en = 1'b1;
    mode3 = 1'b0; do_write(16'h2FFE, 4, "R12");
    mode3 = 1'b1; do_write(16'h3FFF, 2, "R12");
    deny_en = 1'b0;

    mode3 = 1'b0;
    begin_tx(); xbyte(8'h03, rx, oen); xbyte(8'h01, rx, oen); xbyte(8'h00, rx, oen);
    rx = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = 1'($urandom); #(HALF);
      if (i == 4) begin
        hold_n = 1'b0; #(HALF);
        chk(!spi_so_oe, "R10", "hold drops drive", spi_so_oe, 0);
        sck = 1'b1; si = 1'($urandom); #(HALF);
        sck = 1'b0; #(HALF);
        sck = 1'b1; #(HALF);
        hold_n = 1'b1; #(HALF);
        chk(!spi_so_oe, "R10", "release with clock high", spi_so_oe, 0);
        sck = 1'b0; #(HALF);
        chk(spi_so_oe, "R10", "hold ends on clock low", spi_so_oe, 1);
      end
      rx[i] = spi_so;
      sck = 1'b1; #(HALF);
    end
    chk(rx == pat(14'h0100), "R10", "byte across hold", rx, pat(14'h0100));
    xbyte(8'h00, rx, oen);
    chk(rx == pat(14'h0101), "R10", "byte after hold", rx, pat(14'h0101));
    end_tx();

    mode3 = 1'b1; w0 = wcnt; e1 = n_wren; e2 = n_wrend;
    begin_tx(); xbyte(8'h02, rx, oen); xbyte(8'h02, rx, oen); xbyte(8'h00, rx, oen);
    for (int i = 0; i < 4; i++) xbit(1'b1, o, o);
    sck = 1'b0; #(HALF);
    hold_n = 1'b0; #(HALF);
    cs_n = 1'b1; #(HALF);
    hold_n = 1'b1; sck = 1'b1; #(HALF * 4);
    for (int i = 0; i < 4; i++) begin
      begin_tx(); xbit(1'b1, o, o); end_tx();
    end
    chk(wcnt == w0, "R11", "aborted byte not written", wcnt - w0, 0);
    cmd_only(8'h06);
    chk(n_wren == e1 + 1, "R11", "fresh command after abort", n_wren, e1 + 1);
    chk(n_wrend == e2 + 1, "R13", "write-end on abort", n_wrend, e2 + 1);
    do_write(16'h0200, 1, "R11");

    for (int t = 0; t < 40; t++) begin
      mode3 = 1'($urandom);
      deny_en = ($urandom % 4) == 0;
      if ($urandom % 2) do_write(16'($urandom), 1 + int'($urandom % 4), "R5");
      else do_read(16'($urandom), 1 + int'($urandom % 4), "R6");
    end
    deny_en = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule